// File: doc/BRIEF.md
# Hardware Task Switch Sequencer

This block performs a complete hardware context switch between tasks. A dispatch request arrives with a kind code (call, jump, interrupt, exception or nested return) and a selector. The selector names either a task state segment directly or a gate that holds the segment selector. The sequencer first resolves the target task. It then checks that the switch is allowed. Next it writes the running task's eight-word context into that task's own segment, through a word-addressed memory port. Only after that does it read the incoming task's eight words into its context register file.

A call, interrupt or exception also does two more things. It writes the outgoing task's selector into the link word of the incoming segment, and it sets the nested-task flag in the loaded flags word. A nested return follows the link word of the current segment back to the caller.

Every rejected request ends with a status code and changes nothing. This covers a switch to the running task, a direct selector on an interrupt or exception path, a gate that points at another gate, a call or jump to a task that is already busy, and a return with the nested flag clear. The surrounding core supplies the live context on `cur_ctx_i` and takes the loaded context from `ctx_o`.

Top module: `tsw_seq`

## Requirements
- R1: After reset the task register reads INIT_TASK, `busy_o`, `done_o` and `mem_we_o` are low, and `status_o` is 0.
- R2: A switch that is accepted writes the outgoing context to offsets 0..7 of the outgoing segment, in the order of the `cur_ctx_i` words: word 0 instruction pointer, word 1 flags, words 2-5 general registers, word 6 descriptor-table selector, word 7 page-table base. The segment starts at address index<<SEG_SHIFT. All eight writes come before any read of the incoming segment. Once the switch finishes, `ctx_o` holds words 0..7 of the incoming segment, the task register holds the new index, and `done_o` pulses with status 0.
- R3: A selector with bit SEL_W-1 set is a gate. Its gate word is read at GATE_BASE+index, and the low IDX_W bits of that word name the target segment. A gate word with bit SEL_W-1 set ends the request with status 5.
- R4: An interrupt (kind 2) or exception (kind 3) that carries a direct selector ends with status 2. Through a gate it switches normally.
- R5: On call (kind 0), interrupt or exception, the outgoing selector is written to offset 8 of the incoming segment, and bit NT_BIT of the loaded flags word is set. On jump (kind 1), offset 8 is not written and the flags word stays as read.
- R6: A target index equal to the running task ends with status 1. There are no memory writes and the task register does not change.
- R7: Each task has a busy bit. It is set when the task is entered and cleared when the task is left by jump or return. A call or jump to a busy task ends with status 3 and no writes.
- R8: A return (kind 4) whose current flags word has bit NT_BIT set reads offset 8 of the current segment and switches to that task without writing any link. With the bit clear, it ends with status 4.
- R9: A request is ignored while `busy_o` is high, and kinds 5-7 are never accepted. An ignored request produces no `done_o` and no memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Dispatch request strobe |
| req_kind | input | 3 | 0 call, 1 jump, 2 interrupt, 3 exception, 4 nested return |
| req_sel | input | SEL_W | Target selector; top bit marks a gate |
| cur_ctx_i | input | 8*DATA_W | Live context of the running task, word 0 in the low bits |
| busy_o | output | 1 | Sequencer is working on a request |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 3 | Result code, valid with `done_o` |
| task_reg_o | output | SEL_W | Selector of the running task |
| ctx_o | output | 8*DATA_W | Context loaded from the incoming segment |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, same cycle as the address |

## Verification
The bench builds the block with IDX_W=3, ADDR_W=8 and GATE_BASE=128. With these values eight segments and their gates fit in a 256-word array that the bench owns and can inspect word by word. The small index range lets one directed run reach many situations: every fault code, a busy chain of call, jump, exception and return, a gate that names another gate, and a self-switch that is reached both directly and through a gate.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
   typedef enum logic [2:0] {
      K_CALL = 3'd0,
      K_JUMP = 3'd1,
      K_INTR = 3'd2,
      K_EXCP = 3'd3,
      K_RETN = 3'd4
   } kind_e;

   typedef enum logic [2:0] {
      ST_OK        = 3'd0,
      ST_SELF      = 3'd1,
      ST_NOGATE    = 3'd2,
      ST_BUSY      = 3'd3,
      ST_NOTNESTED = 3'd4,
      ST_BADGATE   = 3'd5
   } stat_e;

   typedef enum logic [3:0] {
      S_IDLE, S_GATE, S_LINKRD, S_CHECK, S_SAVE, S_LOAD, S_LINKWR, S_FIN
   } state_e;

   localparam int CTX_WORDS = 8;
   localparam int LINK_OFS  = 8;
   localparam int FLAGS_POS = 1;

   function automatic logic kind_links(kind_e k);
      return (k == K_CALL) || (k == K_INTR) || (k == K_EXCP);
   endfunction
endpackage

// File: rtl/tsw_sel_decode.sv
module tsw_sel_decode #(
   parameter int SEL_W     = 16,
   parameter int IDX_W     = 4,
   parameter int ADDR_W    = 10,
   parameter int GATE_BASE = 512
) (
   input  logic [SEL_W-1:0]  sel,
   output logic              is_gate,
   output logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] gate_addr
);
   logic unused_mid;

   assign is_gate   = sel[SEL_W-1];
   assign idx       = sel[IDX_W-1:0];
   assign gate_addr = ADDR_W'(GATE_BASE) + ADDR_W'(idx);
   assign unused_mid = ^sel[SEL_W-2:IDX_W];
endmodule

// File: rtl/tsw_busy_map.sv
module tsw_busy_map #(
   parameter int IDX_W     = 4,
   parameter int INIT_TASK = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [IDX_W-1:0] set_idx,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx,
   input  logic [IDX_W-1:0] q_idx,
   output logic             q_busy
);
   localparam int NTASK = 1 << IDX_W;

   logic [NTASK-1:0] bits_q;

   for (genvar t = 0; t < NTASK; t++) begin : g_task
      always_ff @(posedge clk) begin
         if (!rst_n)
            bits_q[t] <= (t == INIT_TASK);
         else if (set_en && set_idx == IDX_W'(t))
            bits_q[t] <= 1'b1;
         else if (clr_en && clr_idx == IDX_W'(t))
            bits_q[t] <= 1'b0;
      end
   end

   assign q_busy = bits_q[q_idx];
endmodule

// File: rtl/tsw_ctx_file.sv
module tsw_ctx_file #(
   parameter int DATA_W    = 32,
   parameter int WORDS     = 8,
   parameter int FLAGS_POS = 1,
   parameter int NT_BIT    = 14
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [$clog2(WORDS)-1:0] wr_idx,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     set_nt,
   output logic [WORDS*DATA_W-1:0]  ctx_o
);
   localparam int WI_W = $clog2(WORDS);

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [DATA_W-1:0] q;
      if (w == FLAGS_POS) begin : g_flags
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && wr_idx == WI_W'(w))
               q <= wr_data;
            else if (set_nt)
               q[NT_BIT] <= 1'b1;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && wr_idx == WI_W'(w))
               q <= wr_data;
         end
      end
      assign ctx_o[w*DATA_W +: DATA_W] = q;
   end
endmodule

// File: rtl/tsw_seq.sv
module tsw_seq
   import tsw_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int SEL_W     = 16,
   parameter int IDX_W     = 4,
   parameter int SEG_SHIFT = 4,
   parameter int ADDR_W    = 10,
   parameter int GATE_BASE = 512,
   parameter int NT_BIT    = 14,
   parameter int INIT_TASK = 0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [2:0]                  req_kind,
   input  logic [SEL_W-1:0]            req_sel,
   input  logic [CTX_WORDS*DATA_W-1:0] cur_ctx_i,
   output logic                        busy_o,
   output logic                        done_o,
   output logic [2:0]                  status_o,
   output logic [SEL_W-1:0]            task_reg_o,
   output logic [CTX_WORDS*DATA_W-1:0] ctx_o,
   output logic                        mem_rd_o,
   output logic                        mem_we_o,
   output logic [ADDR_W-1:0]           mem_addr_o,
   output logic [DATA_W-1:0]           mem_wdata_o,
   input  logic [DATA_W-1:0]           mem_rdata_i
);
   localparam int CNT_W = $clog2(CTX_WORDS);
   localparam int NTASK = 1 << IDX_W;
   localparam int SEG_SPAN = NTASK << SEG_SHIFT;

   if (SEG_SHIFT < 4) begin : g_bad_shift
      $error("SEG_SHIFT must leave room for nine words per segment");
   end
   if (IDX_W >= SEL_W - 1) begin : g_bad_idx
      $error("IDX_W must be below SEL_W-1");
   end
   if (DATA_W < SEL_W || NT_BIT >= DATA_W) begin : g_bad_data
      $error("DATA_W must hold a selector and the nested flag");
   end
   if (GATE_BASE < SEG_SPAN || GATE_BASE + NTASK > (1 << ADDR_W)) begin : g_bad_map
      $error("gate table must sit above the segments and inside the address space");
   end
   if (INIT_TASK >= NTASK) begin : g_bad_init
      $error("INIT_TASK out of range");
   end

   state_e             state_q;
   kind_e              kind_q;
   stat_e              status_q;
   logic               done_q;
   logic [IDX_W-1:0]   tr_q, tgt_q, sel_idx_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [CTX_WORDS*DATA_W-1:0] snap_q;

   logic               req_gate;
   logic [IDX_W-1:0]   req_idx;
   logic [ADDR_W-1:0]  req_gate_addr;
   logic [ADDR_W-1:0]  gate_addr_q;
   logic [ADDR_W-1:0]  cur_base, tgt_base;
   logic               tgt_busy;
   logic               cur_nt;
   logic               accept;
   kind_e              req_k;
   logic               fin;

   tsw_sel_decode #(
      .SEL_W(SEL_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .GATE_BASE(GATE_BASE)
   ) u_dec (
      .sel(req_sel), .is_gate(req_gate), .idx(req_idx), .gate_addr(req_gate_addr)
   );

   assign fin = (state_q == S_FIN);

   tsw_busy_map #(.IDX_W(IDX_W), .INIT_TASK(INIT_TASK)) u_busy (
      .clk(clk), .rst_n(rst_n),
      .set_en(fin), .set_idx(tgt_q),
      .clr_en(fin && (kind_q == K_JUMP || kind_q == K_RETN)), .clr_idx(tr_q),
      .q_idx(tgt_q), .q_busy(tgt_busy)
   );

   tsw_ctx_file #(
      .DATA_W(DATA_W), .WORDS(CTX_WORDS), .FLAGS_POS(FLAGS_POS), .NT_BIT(NT_BIT)
   ) u_ctx (
      .clk(clk), .rst_n(rst_n),
      .wr_en(state_q == S_LOAD), .wr_idx(cnt_q), .wr_data(mem_rdata_i),
      .set_nt(fin && kind_links(kind_q)),
      .ctx_o(ctx_o)
   );

   assign req_k    = kind_e'(req_kind);
   assign accept   = req_valid && (state_q == S_IDLE) && (req_kind <= 3'd4);
   assign cur_nt   = cur_ctx_i[FLAGS_POS*DATA_W + NT_BIT];
   assign cur_base = ADDR_W'(tr_q) << SEG_SHIFT;
   assign tgt_base = ADDR_W'(tgt_q) << SEG_SHIFT;

   always_comb begin
      mem_rd_o    = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = '0;
      mem_wdata_o = '0;
      unique case (state_q)
         S_GATE: begin
            mem_rd_o   = 1'b1;
            mem_addr_o = gate_addr_q;
         end
         S_LINKRD: begin
            mem_rd_o   = 1'b1;
            mem_addr_o = cur_base + ADDR_W'(LINK_OFS);
         end
         S_SAVE: begin
            mem_we_o    = 1'b1;
            mem_addr_o  = cur_base + ADDR_W'(cnt_q);
            mem_wdata_o = snap_q[cnt_q*DATA_W +: DATA_W];
         end
         S_LOAD: begin
            mem_rd_o   = 1'b1;
            mem_addr_o = tgt_base + ADDR_W'(cnt_q);
         end
         S_LINKWR: begin
            mem_we_o    = 1'b1;
            mem_addr_o  = tgt_base + ADDR_W'(LINK_OFS);
            mem_wdata_o = DATA_W'(tr_q);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         kind_q      <= K_JUMP;
         status_q    <= ST_OK;
         done_q      <= 1'b0;
         tr_q        <= IDX_W'(INIT_TASK);
         tgt_q       <= '0;
         sel_idx_q   <= '0;
         gate_addr_q <= '0;
         cnt_q       <= '0;
         snap_q      <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            S_IDLE: if (accept) begin
               kind_q      <= req_k;
               snap_q      <= cur_ctx_i;
               sel_idx_q   <= req_idx;
               gate_addr_q <= req_gate_addr;
               if (req_k == K_RETN) begin
                  if (cur_nt) state_q <= S_LINKRD;
                  else begin
                     done_q   <= 1'b1;
                     status_q <= ST_NOTNESTED;
                  end
               end else if (req_gate) begin
                  state_q <= S_GATE;
               end else if (req_k == K_INTR || req_k == K_EXCP) begin
                  done_q   <= 1'b1;
                  status_q <= ST_NOGATE;
               end else begin
                  tgt_q   <= req_idx;
                  state_q <= S_CHECK;
               end
            end
            S_GATE: begin
               if (mem_rdata_i[SEL_W-1]) begin
                  done_q   <= 1'b1;
                  status_q <= ST_BADGATE;
                  state_q  <= S_IDLE;
               end else begin
                  tgt_q   <= mem_rdata_i[IDX_W-1:0];
                  state_q <= S_CHECK;
               end
            end
            S_LINKRD: begin
               tgt_q   <= mem_rdata_i[IDX_W-1:0];
               state_q <= S_CHECK;
            end
            S_CHECK: begin
               if (tgt_q == tr_q) begin
                  done_q   <= 1'b1;
                  status_q <= ST_SELF;
                  state_q  <= S_IDLE;
               end else if (tgt_busy && (kind_q == K_CALL || kind_q == K_JUMP)) begin
                  done_q   <= 1'b1;
                  status_q <= ST_BUSY;
                  state_q  <= S_IDLE;
               end else begin
                  cnt_q   <= '0;
                  state_q <= S_SAVE;
               end
            end
            S_SAVE: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CNT_W'(CTX_WORDS-1)) state_q <= S_LOAD;
            end
            S_LOAD: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CNT_W'(CTX_WORDS-1))
                  state_q <= kind_links(kind_q) ? S_LINKWR : S_FIN;
            end
            S_LINKWR: state_q <= S_FIN;
            S_FIN: begin
               tr_q     <= tgt_q;
               done_q   <= 1'b1;
               status_q <= ST_OK;
               state_q  <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q != S_IDLE);
   assign done_o     = done_q;
   assign status_o   = status_q;
   assign task_reg_o = SEL_W'(tr_q);
endmodule

// File: rtl/tsw_seq_chk.sv
module tsw_seq_chk #(
   parameter int SEL_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [2:0]       req_kind,
   input logic             busy_o,
   input logic             done_o,
   input logic [2:0]       status_o,
   input logic [SEL_W-1:0] task_reg_o,
   input logic             mem_we_o
);
   logic [4:0] wcnt;
   logic [2:0] kind_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcnt   <= '0;
         kind_q <= 3'd1;
      end else if (req_valid && !busy_o) begin
         wcnt   <= '0;
         kind_q <= req_kind;
      end else if (mem_we_o) begin
         wcnt <= wcnt + 1'b1;
      end
   end

   // R5: linking kinds write eight context words and one link word
   assert_link_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o == 3'd0 && (kind_q == 3'd0 || kind_q == 3'd2 || kind_q == 3'd3))
      |-> wcnt == 5'd9);

   // R2: jump and return write only the eight context words
   assert_plain_writes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o == 3'd0 && (kind_q == 3'd1 || kind_q == 3'd4))
      |-> wcnt == 5'd8);

   // R6: a rejected request leaves memory untouched
   assert_fault_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o != 3'd0) |-> wcnt == 5'd0);

   // R2: the task register moves only with a successful completion
   assert_tr_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(task_reg_o) |-> (done_o && status_o == 3'd0));

   // R6: a successful switch never lands on the task it left
   assert_no_self_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o == 3'd0) |-> task_reg_o != $past(task_reg_o));
endmodule

bind tsw_seq tsw_seq_chk #(.SEL_W(SEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
   .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
   .task_reg_o(task_reg_o), .mem_we_o(mem_we_o)
);

// File: tb/tsw_seq_tb.sv
module tsw_seq_tb;
   localparam int DW = 32, SW = 16, IW = 3, SS = 4, AW = 8, GB = 128, NTB = 14;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [2:0] req_kind = '0;
   logic [SW-1:0] req_sel = '0;
   logic [8*DW-1:0] cur_ctx = '0;
   logic busy_o, done_o, mem_rd_o, mem_we_o;
   logic [2:0] status_o;
   logic [SW-1:0] task_reg_o;
   logic [8*DW-1:0] ctx_o;
   logic [AW-1:0] mem_addr_o;
   logic [DW-1:0] mem_wdata_o, mem_rdata;

   logic [DW-1:0] mem [0:(1<<AW)-1];
   int wcount = 0, tests = 0, fails = 0, cyc = 0;
   logic [2:0] got_status;
   logic [SW-1:0] got_tr;

   always #5 clk = ~clk;

   tsw_seq #(.DATA_W(DW), .SEL_W(SW), .IDX_W(IW), .SEG_SHIFT(SS), .ADDR_W(AW),
             .GATE_BASE(GB), .NT_BIT(NTB), .INIT_TASK(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_sel(req_sel), .cur_ctx_i(cur_ctx), .busy_o(busy_o), .done_o(done_o),
      .status_o(status_o), .task_reg_o(task_reg_o), .ctx_o(ctx_o),
      .mem_rd_o(mem_rd_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata));

   assign mem_rdata = mem[mem_addr_o];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_we_o) begin
         mem[mem_addr_o] <= mem_wdata_o;
         wcount <= wcount + 1;
      end
   end

   always @(posedge clk) if (cyc == 20000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   function automatic logic [DW-1:0] seg_word(int t, int k);
      return 32'h1000_0000 | (t << 8) | k;
   endfunction

   function automatic logic [DW-1:0] live_word(logic [15:0] seed, int k, bit nt);
      return {seed, 16'h0} | k | ((nt && k == 1) ? (32'h1 << NTB) : 32'h0);
   endfunction

   task automatic chk(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      tests = tests + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic run_op(input logic [2:0] kind, input logic [SW-1:0] sel,
                         input logic [15:0] seed, input bit nt, input bit poke);
      @(negedge clk);
      for (int k = 0; k < 8; k++) cur_ctx[k*DW +: DW] = live_word(seed, k, nt);
      wcount    = 0;
      req_kind  = kind;
      req_sel   = sel;
      req_valid = 1'b1;
      got_status = 3'd7;
      for (int n = 0; n < 100; n++) begin
         @(negedge clk);
         req_valid = 1'b0;
         if (poke && n == 3) begin
            req_kind = 3'd0; req_sel = 16'd5; req_valid = 1'b1;
         end
         if (done_o) begin
            got_status = status_o;
            got_tr     = task_reg_o;
            break;
         end
      end
      req_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 task register", 32'(task_reg_o), 32'd0);
      chk("R1 busy", 32'(busy_o), 32'd0);
      chk("R1 done", 32'(done_o), 32'd0);
      chk("R1 status", 32'(status_o), 32'd0);
      chk("R1 no write", 32'(mem_we_o), 32'd0);
   endtask

   task automatic t_jump_direct;
      run_op(3'd1, 16'd1, 16'hA001, 1'b0, 1'b0);
      chk("R2 status", 32'(got_status), 32'd0);
      chk("R2 task register", 32'(got_tr), 32'd1);
      chk("R2 write count", wcount, 32'd8);
      for (int k = 0; k < 8; k++) begin
         chk("R2 saved word", mem[k], live_word(16'hA001, k, 1'b0));
         chk("R2 loaded word", ctx_o[k*DW +: DW], seg_word(1, k));
      end
      chk("R5 jump leaves link", mem[16+8], 32'hDEAD);
   endtask

   task automatic t_call_gate;
      run_op(3'd0, 16'h8003, 16'hA002, 1'b0, 1'b0);
      chk("R3 gate status", 32'(got_status), 32'd0);
      chk("R3 gate target", 32'(got_tr), 32'd2);
      chk("R5 link word", mem[32+8], 32'd1);
      chk("R5 nested flag", ctx_o[DW +: DW], seg_word(2, 1) | (32'h1 << NTB));
      chk("R5 write count", wcount, 32'd9);
      chk("R2 saved ip", mem[16], live_word(16'hA002, 0, 1'b0));
   endtask

   task automatic t_faults;
      run_op(3'd0, 16'd1, 16'hB001, 1'b0, 1'b0);
      chk("R7 busy call", 32'(got_status), 32'd3);
      chk("R7 no writes", wcount, 32'd0);
      run_op(3'd0, 16'd2, 16'hB002, 1'b0, 1'b0);
      chk("R6 self direct", 32'(got_status), 32'd1);
      chk("R6 no writes", wcount, 32'd0);
      chk("R6 task register", 32'(got_tr), 32'd2);
      run_op(3'd1, 16'h8004, 16'hB003, 1'b0, 1'b0);
      chk("R6 self via gate", 32'(got_status), 32'd1);
      run_op(3'd2, 16'd5, 16'hB004, 1'b0, 1'b0);
      chk("R4 direct interrupt", 32'(got_status), 32'd2);
      chk("R4 no writes", wcount, 32'd0);
      run_op(3'd1, 16'h8006, 16'hB005, 1'b0, 1'b0);
      chk("R3 gate to gate", 32'(got_status), 32'd5);
      chk("R6 ctx unchanged", ctx_o[0 +: DW], seg_word(2, 0));
   endtask

   task automatic t_return;
      run_op(3'd4, 16'd0, 16'hA007, 1'b1, 1'b0);
      chk("R8 status", 32'(got_status), 32'd0);
      chk("R8 back to caller", 32'(got_tr), 32'd1);
      chk("R8 write count", wcount, 32'd8);
      for (int k = 0; k < 8; k++)
         chk("R8 restored word", ctx_o[k*DW +: DW], live_word(16'hA002, k, 1'b0));
      chk("R8 no link written", mem[16+8], 32'hDEAD);
      chk("R8 outgoing saved flags", mem[33], live_word(16'hA007, 1, 1'b1));
      run_op(3'd4, 16'd0, 16'hA008, 1'b0, 1'b0);
      chk("R8 not nested", 32'(got_status), 32'd4);
      chk("R8 task kept", 32'(got_tr), 32'd1);
   endtask

   task automatic t_busy_release;
      run_op(3'd1, 16'd2, 16'hA009, 1'b0, 1'b0);
      chk("R7 cleared by return", 32'(got_status), 32'd0);
      chk("R7 task register", 32'(got_tr), 32'd2);
      chk("R5 jump keeps flags", ctx_o[DW +: DW], live_word(16'hA007, 1, 1'b1));
      chk("R5 jump keeps link", mem[32+8], 32'd1);
      run_op(3'd3, 16'h8007, 16'hA00A, 1'b0, 1'b0);
      chk("R4 exception via gate", 32'(got_status), 32'd0);
      chk("R4 target", 32'(got_tr), 32'd3);
      chk("R5 exception link", mem[48+8], 32'd2);
      chk("R5 exception flag", ctx_o[DW +: DW], seg_word(3, 1) | (32'h1 << NTB));
   endtask

   task automatic t_ignore;
      run_op(3'd1, 16'd0, 16'hA00B, 1'b0, 1'b1);
      chk("R9 first op", 32'(got_status), 32'd0);
      chk("R9 target", 32'(got_tr), 32'd0);
      begin
         int extra = 0;
         for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            if (done_o || busy_o) extra = extra + 1;
         end
         chk("R9 no second op", extra, 32'd0);
      end
      chk("R9 task register", 32'(task_reg_o), 32'd0);
      chk("R9 no link written", mem[80+8], 32'hDEAD);
      @(negedge clk);
      req_kind = 3'd6; req_sel = 16'd3; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 bad kind busy", 32'(busy_o), 32'd0);
      chk("R9 bad kind done", 32'(done_o), 32'd0);
      run_op(3'd1, 16'd2, 16'hA00C, 1'b0, 1'b0);
      chk("R7 still busy after exception", 32'(got_status), 32'd3);
      run_op(3'd1, 16'd3, 16'hA00D, 1'b0, 1'b0);
      chk("R7 cleared by jump", 32'(got_status), 32'd0);
   endtask

   initial begin
      for (int a = 0; a < (1 << AW); a++) mem[a] = 32'h0;
      for (int t = 0; t < 8; t++) begin
         for (int k = 0; k < 8; k++) mem[t*16 + k] = seg_word(t, k);
         mem[t*16 + 8] = 32'hDEAD;
      end
      mem[GB+3] = 32'h0000_0002;
      mem[GB+4] = 32'h0000_0002;
      mem[GB+6] = 32'h0000_8001;
      mem[GB+7] = 32'h0000_0003;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_jump_direct();
      t_call_gate();
      t_faults();
      t_return();
      t_busy_release();
      t_ignore();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule